// File: doc/BRIEF.md
# RMII MAC-Side Adapter

This block is the MAC-side logic of a reduced media-independent interface. It runs on a single 50 MHz reference clock and samples and launches every signal on the rising edge. On the transmit side it takes bytes through a valid/ready handshake. It splits each byte into four 2-bit transfers, lowest pair first, and holds the enable high for the length of the frame. On the receive side it samples the 2-bit data and the combined carrier/valid line, drops the preamble, locks byte alignment on the start-of-frame delimiter, and delivers whole bytes with an error flag and an end-of-frame pulse.

Line rate and duplex arrive as configuration inputs. At 100 Mbit/s a transfer slot is one clock. At 10 Mbit/s a slot is ten clocks: each transmit value is held for ten clocks and the receive lines are sampled once per slot. The combined receive line is split into a carrier indication and data validity. In half duplex, a collision flag is raised while the block transmits and sees carrier.

Top module: `rmii_mac_adapter`

## Requirements
- R1: After reset, rmii_txen_o, rmii_txd_o, rx_valid_o, rx_last_o, carrier_o and col_o are all 0.
- R2: Each transmit byte goes out as four dibits on rmii_txd_o, bits 1:0 first and bits 7:6 last. rmii_txen_o stays high across back-to-back bytes with no gap. rmii_txd_o is 0 whenever rmii_txen_o is low.
- R3: tx_ready_o is high only in a cycle that starts a new slot when the transmitter is idle or on its fourth dibit. A byte is taken when tx_ready_o and tx_valid_i are both high. At 10 Mbit/s, tx_ready_o is never high in two consecutive cycles.
- R4: With speed_10_i=1, every transmit dibit and the enable are held for exactly 10 clocks, and the receive inputs are sampled once per 10 clocks. With speed_10_i=0, a slot is one clock.
- R5: Received dibits before the first dibit 2'b11 in a frame are discarded. That dibit, the last pair of the delimiter byte 0xD5, fixes byte alignment.
- R6: After alignment, every four received dibits form one byte, the earliest in bits 1:0. The byte is presented on rx_data_o with a one-cycle rx_valid_o pulse.
- R7: carrier_o rises on the first slot in which rmii_crs_dv_i is sampled high while no frame is active. It falls on the first slot in the frame in which the line is sampled low, and stays low until the frame ends.
- R8: While rmii_crs_dv_i toggles in alternate slots, the dibits of both the low and the high slots are still taken as data.
- R9: Two consecutive slots with rmii_crs_dv_i low end the frame. The data of those slots and any partial byte are discarded, and rx_last_o pulses for one cycle.
- R10: rx_err_o is 1 with a byte if rmii_rxer_i was high in any of its four dibit slots, and 0 otherwise.
- R11: col_o is high only when full_duplex_i=0, rmii_txen_o=1 and carrier_o=1. It is always 0 in full duplex.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 50 MHz reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| speed_10_i | input | 1 | 1 selects 10 Mbit/s slots of ten clocks |
| full_duplex_i | input | 1 | 1 selects full duplex (collision flag suppressed) |
| tx_data_i | input | 8 | Transmit byte |
| tx_valid_i | input | 1 | Transmit byte available |
| tx_ready_o | output | 1 | Transmit byte taken this cycle when valid |
| rmii_txd_o | output | 2 | Transmit dibit to the PHY |
| rmii_txen_o | output | 1 | Transmit enable to the PHY |
| rmii_rxd_i | input | 2 | Receive dibit from the PHY |
| rmii_crs_dv_i | input | 1 | Combined carrier and data-valid line |
| rmii_rxer_i | input | 1 | Receive error from the PHY |
| rx_data_o | output | 8 | Received byte |
| rx_valid_o | output | 1 | One-cycle strobe for rx_data_o |
| rx_err_o | output | 1 | Error flag for the presented byte |
| rx_last_o | output | 1 | One-cycle end-of-frame pulse |
| carrier_o | output | 1 | Decoded carrier sense |
| col_o | output | 1 | Derived collision flag |

## Verification
The assertions check the cycle-level invariants on every cycle: transmit outputs change only on a slot boundary, slots are spaced apart at 10 Mbit/s, the data lines are quiet while the enable is low, receive strobes are single pulses, the end pulse comes with carrier low, and the collision flag is gated by duplex mode and transmit activity. Only the bench scenarios can show the byte content and its order: dibit ordering on both paths, delimiter alignment after preambles of different lengths, data kept through a toggling carrier tail, per-byte error marking, and collisions appearing only when transmit and receive overlap in half duplex.

// File: rtl/rmii_pkg.sv
package rmii_pkg;
  localparam int DIBIT_W         = 2;
  localparam int BYTE_W          = 8;
  localparam int DIBITS_PER_BYTE = BYTE_W / DIBIT_W;
  localparam int DCNT_W          = $clog2(DIBITS_PER_BYTE);
  localparam logic [DIBIT_W-1:0] SFD_TAIL = 2'b11;
endpackage

// File: rtl/rmii_slot_tick.sv
module rmii_slot_tick #(
  parameter int DIV = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic slow_i,
  output logic tick_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  // R4: one slot per DIV clocks at low rate, every clock otherwise
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (!slow_i || cnt_q == LAST) cnt_q <= '0;
    else                             cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = !slow_i || (cnt_q == '0);
endmodule

// File: rtl/rmii_tx_ser.sv
module rmii_tx_ser
  import rmii_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [BYTE_W-1:0] data_i,
  input  logic              valid_i,
  output logic              ready_o,
  output logic [DIBIT_W-1:0] txd_o,
  output logic              txen_o
);
  logic [BYTE_W-DIBIT_W-1:0] sh_q;
  logic [DCNT_W-1:0]         rem_q;
  logic                      need;

  assign need    = !txen_o || (rem_q == '0);
  assign ready_o = tick_i && need; // R3

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      rem_q  <= '0;
      txd_o  <= '0;
      txen_o <= 1'b0;
    end else if (tick_i) begin
      if (need) begin
        if (valid_i) begin
          txd_o  <= data_i[DIBIT_W-1:0];
          sh_q   <= data_i[BYTE_W-1:DIBIT_W];
          rem_q  <= DCNT_W'(DIBITS_PER_BYTE - 1);
          txen_o <= 1'b1;
        end else begin
          txd_o  <= '0;
          sh_q   <= '0;
          rem_q  <= '0;
          txen_o <= 1'b0;
        end
      end else begin
        txd_o <= sh_q[DIBIT_W-1:0];
        sh_q  <= sh_q >> DIBIT_W;
        rem_q <= rem_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/rmii_rx_deser.sv
module rmii_rx_deser
  import rmii_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic [DIBIT_W-1:0] rxd_i,
  input  logic               crs_dv_i,
  input  logic               rxer_i,
  output logic [BYTE_W-1:0]  data_o,
  output logic               valid_o,
  output logic               err_o,
  output logic               last_o,
  output logic               carrier_o
);
  logic                      in_frame_q, aligned_q, err_acc_q;
  logic [DIBIT_W-1:0]        prev_d_q;
  logic                      prev_crs_q, prev_er_q;
  logic [DCNT_W-1:0]         cnt_q;
  logic [BYTE_W-DIBIT_W-1:0] sr_q;

  // Each dibit is committed one slot late, once the next slot shows whether
  // it belonged to the frame (R8, R9).
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_frame_q <= 1'b0;
      aligned_q  <= 1'b0;
      err_acc_q  <= 1'b0;
      prev_d_q   <= '0;
      prev_crs_q <= 1'b0;
      prev_er_q  <= 1'b0;
      cnt_q      <= '0;
      sr_q       <= '0;
      data_o     <= '0;
      valid_o    <= 1'b0;
      err_o      <= 1'b0;
      last_o     <= 1'b0;
      carrier_o  <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      last_o  <= 1'b0;
      if (tick_i) begin
        if (!in_frame_q) begin
          if (crs_dv_i) begin
            in_frame_q <= 1'b1;
            carrier_o  <= 1'b1; // R7
            prev_d_q   <= rxd_i;
            prev_crs_q <= 1'b1;
            prev_er_q  <= rxer_i;
            aligned_q  <= 1'b0;
            cnt_q      <= '0;
            err_acc_q  <= 1'b0;
          end
        end else if (!prev_crs_q && !crs_dv_i) begin
          in_frame_q <= 1'b0; // R9
          aligned_q  <= 1'b0;
          carrier_o  <= 1'b0;
          last_o     <= 1'b1;
        end else begin
          prev_d_q   <= rxd_i;
          prev_crs_q <= crs_dv_i;
          prev_er_q  <= rxer_i;
          if (!crs_dv_i) carrier_o <= 1'b0;
          if (!aligned_q) begin
            if (prev_d_q == SFD_TAIL) begin // R5
              aligned_q <= 1'b1;
              cnt_q     <= '0;
              err_acc_q <= 1'b0;
            end
          end else if (cnt_q == DCNT_W'(DIBITS_PER_BYTE - 1)) begin
            data_o    <= {prev_d_q, sr_q}; // R6
            valid_o   <= 1'b1;
            err_o     <= err_acc_q | prev_er_q; // R10
            err_acc_q <= 1'b0;
            cnt_q     <= '0;
          end else begin
            sr_q      <= {prev_d_q, sr_q[BYTE_W-DIBIT_W-1:DIBIT_W]};
            cnt_q     <= cnt_q + 1'b1;
            err_acc_q <= err_acc_q | prev_er_q;
          end
        end
      end
    end
  end
endmodule

// File: rtl/rmii_mac_adapter.sv
module rmii_mac_adapter
  import rmii_pkg::*;
#(
  parameter int SLOW_DIV = 10
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               speed_10_i,
  input  logic               full_duplex_i,
  input  logic [BYTE_W-1:0]  tx_data_i,
  input  logic               tx_valid_i,
  output logic               tx_ready_o,
  output logic [DIBIT_W-1:0] rmii_txd_o,
  output logic               rmii_txen_o,
  input  logic [DIBIT_W-1:0] rmii_rxd_i,
  input  logic               rmii_crs_dv_i,
  input  logic               rmii_rxer_i,
  output logic [BYTE_W-1:0]  rx_data_o,
  output logic               rx_valid_o,
  output logic               rx_err_o,
  output logic               rx_last_o,
  output logic               carrier_o,
  output logic               col_o
);
  logic slot_tick;

  rmii_slot_tick #(.DIV(SLOW_DIV)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .slow_i (speed_10_i),
    .tick_o (slot_tick)
  );

  rmii_tx_ser u_tx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (slot_tick),
    .data_i  (tx_data_i),
    .valid_i (tx_valid_i),
    .ready_o (tx_ready_o),
    .txd_o   (rmii_txd_o),
    .txen_o  (rmii_txen_o)
  );

  rmii_rx_deser u_rx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (slot_tick),
    .rxd_i     (rmii_rxd_i),
    .crs_dv_i  (rmii_crs_dv_i),
    .rxer_i    (rmii_rxer_i),
    .data_o    (rx_data_o),
    .valid_o   (rx_valid_o),
    .err_o     (rx_err_o),
    .last_o    (rx_last_o),
    .carrier_o (carrier_o)
  );

  // R11: no dedicated pin, derived from transmit activity and receive carrier
  assign col_o = !full_duplex_i && rmii_txen_o && carrier_o;
endmodule

// File: rtl/rmii_mac_adapter_chk.sv
module rmii_mac_adapter_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       slot_tick,
  input logic       speed_10_i,
  input logic       full_duplex_i,
  input logic [1:0] rmii_txd_o,
  input logic       rmii_txen_o,
  input logic       rx_valid_o,
  input logic       rx_last_o,
  input logic       carrier_o,
  input logic       col_o
);
  a_r4_tx_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !slot_tick |=> ($stable(rmii_txd_o) && $stable(rmii_txen_o)));

  a_r4_slot_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (speed_10_i && slot_tick) |=> !slot_tick);

  a_r2_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rmii_txen_o |-> (rmii_txd_o == 2'b00));

  a_r6_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |=> !rx_valid_o);

  a_r9_end_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_last_o |-> (!carrier_o && !rx_valid_o));

  a_r11_full_duplex: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_duplex_i |-> !col_o);

  a_r11_needs_tx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    col_o |-> rmii_txen_o);
endmodule

bind rmii_mac_adapter rmii_mac_adapter_chk u_chk (.*);

// File: tb/sim_rmii_mac_adapter.sv
module sim_rmii_mac_adapter;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       speed_10_i = 1'b0;
  logic       full_duplex_i = 1'b1;
  logic [7:0] tx_data_i = '0;
  logic       tx_valid_i = 1'b0;
  logic       tx_ready_o;
  logic [1:0] rmii_txd_o;
  logic       rmii_txen_o;
  logic [1:0] rmii_rxd_i = '0;
  logic       rmii_crs_dv_i = 1'b0;
  logic       rmii_rxer_i = 1'b0;
  logic [7:0] rx_data_o;
  logic       rx_valid_o, rx_err_o, rx_last_o, carrier_o, col_o;

  rmii_mac_adapter u0 (.*);

  always #10 clk_i = ~clk_i;

  int checks = 0, errors = 0;
  int per = 1;
  int frames_seen = 0;
  int col_hi = 0;
  logic [7:0] tx_q[$];
  logic [8:0] rx_q[$];
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int seed, input int i);
    return 8'((seed * 7) + (i * 59) + (i * i * 3));
  endfunction

  // transmit monitor: one sample at the start of each slot
  int tx_run = 0, tx_dib = 0;
  logic [7:0] tx_acc = '0;
  always @(negedge clk_i) begin
    if (rmii_txen_o) begin
      if (tx_run % per == 0) begin
        tx_acc = {rmii_txd_o, tx_acc[7:2]};
        tx_dib++;
        if (tx_dib % 4 == 0) begin
          if (tx_q.size() == 0) chk(0, "R2", tx_acc, 0);
          else begin
            logic [7:0] e;
            e = tx_q.pop_front();
            chk(tx_acc == e, "R2", tx_acc, e);
          end
        end
      end
      tx_run++;
    end else if (tx_run != 0) begin
      chk(tx_run == tx_dib * per && tx_dib % 4 == 0, "R4", tx_run, tx_dib * per);
      tx_run = 0;
      tx_dib = 0;
    end
  end

  // receive monitor
  always @(negedge clk_i) begin
    if (rx_valid_o) begin
      if (rx_q.size() == 0) chk(0, "R6", {rx_err_o, rx_data_o}, 0);
      else begin
        logic [8:0] e;
        e = rx_q.pop_front();
        chk({rx_err_o, rx_data_o} == e, e[8] ? "R10" : "R6", {rx_err_o, rx_data_o}, e);
      end
    end
    if (rx_last_o) frames_seen++;
    if (col_o) col_hi++;
  end

  task automatic tx_frame(input int n, input int seed);
    for (int i = 0; i < n; i++) begin
      tx_q.push_back(pat(seed, i));
      tx_data_i  = pat(seed, i);
      tx_valid_i = 1'b1;
      while (!tx_ready_o) @(negedge clk_i);
      @(negedge clk_i);
      if (per > 1) chk(!tx_ready_o, "R3", tx_ready_o, 0);
    end
    tx_valid_i = 1'b0;
  endtask

  task automatic rx_slot(input bit crs, input logic [1:0] d, input bit er);
    rmii_crs_dv_i = crs;
    rmii_rxd_i    = d;
    rmii_rxer_i   = er;
    repeat (per) @(negedge clk_i);
  endtask

  // pre: preamble dibits, tog: trailing dibits with toggling line, ebyte: errored byte or -1
  task automatic rx_frame(input int n, input int seed, input int pre, input int tog,
                          input int ebyte, input logic [1:0] first);
    int total, fs;
    total = n * 4;
    fs = frames_seen;
    for (int i = 0; i < n; i++) rx_q.push_back({(i == ebyte), pat(seed, i)});
    for (int k = 0; k < pre; k++) begin
      rx_slot(1'b1, (k == 0) ? first : 2'b01, 1'b0);
      if (k == 0) chk(carrier_o == 1'b1, "R7", carrier_o, 1);
    end
    rx_slot(1'b1, 2'b11, 1'b0);
    for (int k = 0; k < total; k++) begin
      logic [7:0] b;
      bit crs;
      b = pat(seed, k / 4);
      crs = (k < total - tog) ? 1'b1 : ((total - 1 - k) % 2 == 0);
      if (tog > 0 && k == total - tog) chk(carrier_o == 1'b1, "R7", carrier_o, 1);
      rx_slot(crs, 2'(b >> (2 * (k % 4))), (k / 4 == ebyte) && (k % 4 == 1));
    end
    if (tog >= 2) chk(carrier_o == 1'b0, "R8", carrier_o, 0);
    rx_slot(1'b0, 2'b10, 1'b0);
    rx_slot(1'b0, 2'b01, 1'b0);
    @(negedge clk_i);
    chk(frames_seen == fs + 1, "R9", frames_seen, fs + 1);
    chk(carrier_o == 1'b0, "R9", carrier_o, 0);
  endtask

  task automatic drain;
    while (rmii_txen_o || tx_q.size() != 0 || rx_q.size() != 0) @(negedge clk_i);
    repeat (3) @(negedge clk_i);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk(rmii_txen_o == 0 && rmii_txd_o == 0, "R1", {rmii_txen_o, rmii_txd_o}, 0);
    chk(rx_valid_o == 0 && rx_last_o == 0, "R1", {rx_valid_o, rx_last_o}, 0);
    chk(carrier_o == 0 && col_o == 0, "R1", {carrier_o, col_o}, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);

    // 100 Mbit/s
    tx_frame(5, 1);
    drain();
    tx_frame(1, 9);
    drain();
    rx_frame(4, 2, 7, 0, -1, 2'b01);
    drain();
    rx_frame(5, 3, 3, 6, 1, 2'b00);
    drain();
    rx_frame(3, 4, 1, 5, 2, 2'b10);
    drain();

    // 10 Mbit/s
    speed_10_i = 1'b1;
    per = 10;
    repeat (2) @(negedge clk_i);
    tx_frame(3, 5);
    drain();
    rx_frame(3, 6, 4, 4, 0, 2'b01);
    drain();

    // half duplex overlap at 100 Mbit/s
    speed_10_i = 1'b0;
    per = 1;
    full_duplex_i = 1'b0;
    repeat (2) @(negedge clk_i);
    col_hi = 0;
    fork
      tx_frame(6, 7);
      rx_frame(6, 8, 2, 0, -1, 2'b01);
    join
    drain();
    chk(col_hi > 0, "R11", col_hi, 1);

    full_duplex_i = 1'b1;
    col_hi = 0;
    fork
      tx_frame(6, 10);
      rx_frame(6, 11, 2, 0, -1, 2'b01);
    join
    drain();
    chk(col_hi == 0, "R11", col_hi, 0);
    chk(tx_q.size() == 0 && rx_q.size() == 0, "R6", tx_q.size() + rx_q.size(), 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R1 actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule